// File: doc/BRIEF.md
# MIDI Host Port Interface

This block is the host-facing side of a MIDI port. A host bus sees two byte-wide locations. Offset 0 is the data port: a read takes the oldest byte from a receive queue, and a write hands one byte to an outbound byte sink. Offset 1 is a combined status and command location: a read returns a status byte, and a write passes a command byte to a small command handler.

The receive queue collects bytes coming in from the serial side and the acknowledge bytes that the command handler inserts for each command it accepts. A single holding register drives the outbound sink through a valid/ready handshake, and one busy flag covers both outbound data and pending commands. A single level interrupt tells the host that the receive queue holds something. It is gated by an activate input and is never raised by transmit activity.

Top module: `midi_host_port`

## Requirements
- R1: A status read (host_addr = 1) returns, on host_rdata in the cycle after the read strobe, bit 7 = receive-empty (1 when the queue holds nothing), bit 6 = transmit-busy, and bits 5 to 0 equal to 0.
- R2: A data read (host_addr = 0) returns the oldest queued byte in the cycle after the strobe and removes it; a data read of an empty queue returns the byte last returned by a data read and changes nothing.
- R3: The receive queue holds 16 bytes; a byte arriving on rx_valid while the queue is full is dropped, and rx_overflow becomes 1 and stays 1 until reset.
- R4: A data write accepted while not busy raises tx_valid with tx_byte equal to the written byte in the next cycle; both stay fixed until an edge where tx_ready is 1, after which tx_valid is 0 and the busy flag clears.
- R5: A write to either location made while busy has no effect: tx_byte, the queue and uart_mode are unchanged.
- R6: A command write accepted while not busy queues the acknowledge byte 0xFE at the first following edge where rx_valid is 0; incoming bytes on earlier edges are queued ahead of it, and busy clears when the acknowledge is queued.
- R7: The command 0xFF empties the queue before its acknowledge is queued, so the next data read returns 0xFE and the queue is then empty; it also sets uart_mode to 0.
- R8: The command 0x3F sets uart_mode to 1 when it is processed.
- R9: irq is 1 exactly when activate is 1 and the queue is not empty; after a data read irq stays 1 if bytes remain.
- R10: irq is 0 whenever activate is 0, whatever the queue holds.
- R11: Data writes, command writes and the outbound handshake never change irq while the queue contents and activate are unchanged.
- R12: After reset host_rdata is 0, the queue is empty, irq, tx_valid, uart_mode and rx_overflow are 0, and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access select |
| host_addr | input | 1 | 0 = data port, 1 = status/command |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after the strobe |
| rx_valid | input | 1 | Incoming serial byte present |
| rx_byte | input | 8 | Incoming serial byte |
| tx_valid | output | 1 | Outbound byte present |
| tx_byte | output | 8 | Outbound byte |
| tx_ready | input | 1 | Sink accepts the outbound byte |
| activate | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt: receive data waiting |
| uart_mode | output | 1 | Set by command 0x3F, cleared by 0xFF |
| rx_overflow | output | 1 | Sticky: an incoming byte was dropped |

## Verification
The bound checker watches on every cycle that irq is low while activate is low, that irq implies a non-empty queue, that irq does not move while activate and queue occupancy are steady, that the outbound byte holds under back-pressure and ignores writes made while busy, that tx_valid only rises after an accepted data write, and that the overflow flag is sticky and the queue never exceeds its depth. Byte ordering through the queue, the empty-read repeat, acknowledge insertion and its deferral behind incoming bytes, the flushing reset command, the mode bit and the status byte layout need the bench's scenarios, which compare every read against a reference queue under random and directed traffic.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ACK_BYTE  = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_RESET = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_UART  = 8'h3F;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int STAT_EMPTY_BIT = 7;
  localparam int STAT_BUSY_BIT  = 6;
endpackage

// File: rtl/midi_rx_fifo.sv
module midi_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, waddr;
  logic [CW-1:0] cnt;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full    = (cnt == CW'(DEPTH));
    do_pop  = pop && (cnt != '0) && !flush;
    do_push = push && (flush || !full || do_pop);
    waddr   = flush ? '0 : wr_ptr;
  end

  // storage write port, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[waddr] <= push_data;
  end

  // registered read port, holds its value when nothing is popped
  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (do_pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= do_push ? AW'(1) : '0;
        cnt    <= do_push ? CW'(1) : '0;
      end else begin
        if (do_push) wr_ptr <= ptr_next(wr_ptr);
        if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
      if (push && !do_push) overflow <= 1'b1;
    end
  end

  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/midi_tx_hold.sv
module midi_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/midi_cmd_ctrl.sv
module midi_cmd_ctrl
  import midi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              hold,
  output logic              pending,
  output logic              ack_push,
  output logic              flush,
  output logic              uart_mode
);
  logic [BYTE_W-1:0] cmd_q;
  logic              fire;

  // processing waits for a cycle with no incoming byte so the queue
  // only ever sees one push per edge
  always_comb begin
    fire     = pending && !hold;
    ack_push = fire;
    flush    = fire && (cmd_q == CMD_RESET);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      cmd_q     <= '0;
      uart_mode <= 1'b0;
    end else begin
      if (cmd_load) begin
        pending <= 1'b1;
        cmd_q   <= cmd_data;
      end else if (fire) begin
        pending <= 1'b0;
      end
      if (fire && cmd_q == CMD_UART) uart_mode <= 1'b1;
      else if (flush)                uart_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready,
  input  logic              activate,
  output logic              irq,
  output logic              uart_mode,
  output logic              rx_overflow
);
  logic              busy, cmd_pending, ack_push, fifo_flush;
  logic              wr_ok, data_wr, cmd_wr, data_rd, ctrl_rd;
  logic              fifo_push, rx_empty;
  logic [BYTE_W-1:0] fifo_wdata, fifo_rdata, stat_q;
  logic [CNT_W-1:0]  rx_count;
  logic              src_ctrl_q;

  always_comb begin
    busy       = tx_valid || cmd_pending;
    wr_ok      = host_sel && host_wr && !busy;
    data_wr    = wr_ok && (host_addr == ADDR_DATA);
    cmd_wr     = wr_ok && (host_addr == ADDR_CTRL);
    data_rd    = host_sel && host_rd && (host_addr == ADDR_DATA);
    ctrl_rd    = host_sel && host_rd && (host_addr == ADDR_CTRL);
    fifo_push  = rx_valid || ack_push;
    fifo_wdata = ack_push ? ACK_BYTE : rx_byte;
  end

  midi_rx_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_flush), .push(fifo_push),
    .push_data(fifo_wdata), .pop(data_rd), .rd_data(fifo_rdata),
    .empty(rx_empty), .count(rx_count), .overflow(rx_overflow)
  );

  midi_tx_hold #(.DW(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(data_wr), .load_data(host_wdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_byte)
  );

  midi_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .cmd_load(cmd_wr), .cmd_data(host_wdata),
    .hold(rx_valid), .pending(cmd_pending), .ack_push(ack_push),
    .flush(fifo_flush), .uart_mode(uart_mode)
  );

  // status byte captured at the read edge; source select remembers
  // which location the last read addressed
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q     <= '0;
      src_ctrl_q <= 1'b0;
    end else if (ctrl_rd) begin
      stat_q                 <= '0;
      stat_q[STAT_EMPTY_BIT] <= rx_empty;
      stat_q[STAT_BUSY_BIT]  <= busy;
      src_ctrl_q             <= 1'b1;
    end else if (data_rd) begin
      src_ctrl_q <= 1'b0;
    end
  end

  assign host_rdata = src_ctrl_q ? stat_q : fifo_rdata;
  assign irq        = activate && !rx_empty;
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          host_sel,
  input logic          host_addr,
  input logic          host_wr,
  input logic          tx_valid,
  input logic [7:0]    tx_byte,
  input logic          tx_ready,
  input logic          activate,
  input logic          irq,
  input logic          rx_overflow,
  input logic          busy,
  input logic [CW-1:0] rx_count
);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !activate |-> !irq);

  assert_irq_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_count != '0);

  assert_irq_tx_indep_R11: assert property (@(posedge clk) disable iff (rst)
    ($stable(activate) && $stable(rx_count)) |-> $stable(irq));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  assert_tx_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(host_sel && host_wr && !host_addr && !busy));

  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && host_sel && host_wr) |=> $stable(tx_byte));

  assert_no_overflow_loss_R3: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |=> rx_overflow);

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(DEPTH));
endmodule

bind midi_host_port midi_host_port_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_addr(host_addr),
  .host_wr(host_wr), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .tx_ready(tx_ready), .activate(activate), .irq(irq),
  .rx_overflow(rx_overflow), .busy(busy), .rx_count(rx_count)
);

// File: tb/sim_midi_host_port.sv
module sim_midi_host_port;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_sel, host_addr, host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_byte;
  logic       activate, irq, uart_mode, rx_overflow;

  always #4 clk = ~clk;

  midi_host_port u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .activate(activate), .irq(irq), .uart_mode(uart_mode),
    .rx_overflow(rx_overflow)
  );

  int         n_checks = 0;
  int         n_fail   = 0;
  logic [7:0] mq[$];
  logic [7:0] last_rd  = 8'h00;
  logic       ovf_m    = 1'b0;

  function automatic logic [7:0] exp_status(input int n, input bit b);
    return {(n == 0), b, 6'b0};
  endfunction

  function automatic logic exp_irq(input bit act, input int n);
    return act && (n != 0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rx_in(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    step();
    rx_valid = 1'b0;
    if (mq.size() < 16) mq.push_back(b);
    else ovf_m = 1'b1;
  endtask

  task automatic read_data(input string tag);
    host_sel = 1'b1; host_rd = 1'b1; host_addr = 1'b0;
    step();
    host_sel = 1'b0; host_rd = 1'b0;
    if (mq.size() > 0) last_rd = mq.pop_front();
    chk(tag, host_rdata, last_rd);
  endtask

  task automatic read_stat(input string tag, input logic [7:0] exp);
    host_sel = 1'b1; host_rd = 1'b1; host_addr = 1'b1;
    step();
    host_sel = 1'b0; host_rd = 1'b0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic host_write(input logic a, input logic [7:0] b);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = b;
    step();
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; host_sel = 0; host_addr = 0; host_rd = 0; host_wr = 0;
    host_wdata = 0; rx_valid = 0; rx_byte = 0; tx_ready = 0; activate = 1;
    repeat (3) step();
    rst = 1'b0;

    // R12 reset state
    chk("R12 rdata", host_rdata, 8'h00);
    chk("R12 irq", irq, 1'b0);
    chk("R12 tx_valid", tx_valid, 1'b0);
    chk("R12 uart_mode", uart_mode, 1'b0);
    chk("R12 overflow", rx_overflow, 1'b0);
    read_stat("R1 R12 status after reset", exp_status(0, 0));

    // R2 ordering, R9 level across reads
    rx_in(8'h90); rx_in(8'h3C); rx_in(8'h64);
    chk("R9 irq with data", irq, 1'b1);
    read_stat("R1 status with data", exp_status(mq.size(), 0));
    read_data("R2 first byte");
    chk("R9 irq stays after read", irq, exp_irq(1, mq.size()));
    read_data("R2 second byte");
    read_data("R2 third byte");
    chk("R9 irq clears when drained", irq, 1'b0);
    read_data("R2 empty read repeats last");
    read_stat("R2 empty read no change", exp_status(0, 0));

    // R10 gating
    rx_in(8'h11);
    activate = 1'b0; #1;
    chk("R10 irq gated", irq, 1'b0);
    activate = 1'b1; #1;
    chk("R9 irq ungated", irq, 1'b1);

    // R4 R5 R11 transmit path with a byte waiting
    host_write(1'b0, 8'hC5);
    chk("R4 tx_valid", tx_valid, 1'b1);
    chk("R4 tx_byte", tx_byte, 8'hC5);
    chk("R11 irq after tx write", irq, 1'b1);
    read_stat("R1 R4 busy status", exp_status(mq.size(), 1));
    host_write(1'b0, 8'h12);
    chk("R5 data write while busy", tx_byte, 8'hC5);
    host_write(1'b1, 8'h3F);
    step(); step();
    chk("R5 cmd write while busy mode", uart_mode, 1'b0);
    read_stat("R5 cmd write while busy queue", exp_status(mq.size(), 1));
    chk("R4 held under backpressure", tx_valid, 1'b1);
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
    chk("R4 tx_valid drops", tx_valid, 1'b0);
    chk("R11 irq after handshake", irq, 1'b1);
    read_stat("R4 busy clears", exp_status(mq.size(), 0));
    read_data("R5 queue untouched");

    // R6 R8 command acknowledge and mode
    host_write(1'b1, 8'h3F);
    step();
    mq.push_back(8'hFE);
    chk("R8 uart_mode set", uart_mode, 1'b1);
    read_stat("R6 ack queued busy clear", exp_status(mq.size(), 0));
    read_data("R6 ack byte");

    // R6 deferral behind incoming bytes
    host_write(1'b1, 8'h01);
    rx_valid = 1'b1; rx_byte = 8'hA1; step(); mq.push_back(8'hA1);
    rx_byte = 8'hA2; step(); mq.push_back(8'hA2);
    rx_valid = 1'b0; step(); mq.push_back(8'hFE);
    read_data("R6 deferred first");
    read_data("R6 deferred second");
    read_data("R6 deferred ack last");

    // R7 reset command flushes
    rx_in(8'h21); rx_in(8'h22); rx_in(8'h23);
    host_write(1'b1, 8'hFF);
    step();
    mq.delete(); mq.push_back(8'hFE);
    chk("R7 uart_mode cleared", uart_mode, 1'b0);
    read_data("R7 ack after flush");
    read_stat("R7 empty after flush", exp_status(0, 0));

    // R3 overflow
    for (int i = 0; i < 17; i++) rx_in(8'(8'h40 + i));
    chk("R3 overflow set", rx_overflow, ovf_m);
    read_stat("R3 full status", exp_status(mq.size(), 0));
    for (int i = 0; i < 16; i++) read_data("R3 kept bytes");
    read_stat("R3 drained", exp_status(0, 0));
    chk("R3 overflow sticky", rx_overflow, 1'b1);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 6);
      if (op == 0) begin
        activate = ~activate; #1;
      end else if (op <= 2) begin
        rx_in(8'($urandom));
      end else if (op <= 4) begin
        read_data("R2 random read");
      end else begin
        read_stat("R1 random status", exp_status(mq.size(), 0));
      end
      chk("R9 R10 random irq", irq, exp_irq(activate, mq.size()));
    end
    chk("R3 random overflow", rx_overflow, ovf_m);

    summary();
    $finish;
  end
endmodule